// File: doc/BRIEF.md
# Mailbox Target Register File

This block is the target side of a byte-addressed mailbox. A host reaches it through a byte-wide register port with one write strobe, such as the back end of a serial bus slave. The host loads a command code and a 32-bit argument into the inbound message bytes. It then rings a doorbell by writing 0x01 to the software-interrupt register. A sequencer hands the request to an internal service port. A small command responder serves it after a fixed latency and returns a 32-bit result. The result is posted into outbound bytes 1 to 4, and a completion flag in the status register is set.

The responder knows four commands, all in milliwatts: a power reading, a limit write, a limit read and a maximum-limit read. It keeps the power limit in its own register. The power reading and the maximum come from input ports. The completion flag stays set until the host writes a 1 to it. An alert output follows the flag unless a mask bit in the control register is set.

The sequencer has four named states:
- SEQ_IDLE: waiting. An accepted doorbell moves it to SEQ_ISSUE.
- SEQ_ISSUE: presents the request to the responder for one cycle, then always moves to SEQ_WAIT.
- SEQ_WAIT: waits. A response moves it to SEQ_POST.
- SEQ_POST: writes the result and the completion flag for one cycle, then always returns to SEQ_IDLE.

Top module: `mbx_target`

## Requirements
- R1: After reset, control (0x01), status (0x02) and every inbound and outbound byte read 0x00, the power limit is 0, and `alert` is low.
- R2: Control (0x01) and inbound bytes 0x38 to 0x3F read back what was last written. Host writes to outbound bytes 0x30 to 0x37 have no effect. Addresses outside the map, and the software-interrupt register 0x40, read 0x00. Writes to unmapped addresses change nothing.
- R3: A request starts only on a write of exactly 0x01 to address 0x40. Any other value written there starts nothing.
- R4: Once serviced, the 32-bit result appears in outbound bytes 0x31 (least significant byte) to 0x34 (most significant byte), and status bit 1 becomes 1. The command code is taken from 0x38 and the argument from 0x39 (LSB) to 0x3C (MSB).
- R5: Writing status with bit 1 = 1 clears the completion flag. Writing it with bit 1 = 0 leaves the flag as it is.
- R6: `alert` is high exactly while the completion flag is 1 and control bit 4 is 0. Control bit 4 = 1 masks it.
- R7: Command 0x01 returns the value on `pwr_meas_mw`.
- R8: Command 0x02 stores the argument as the new power limit, saturated to `pwr_max_mw`. It returns the stored value.
- R9: Command 0x03 returns the stored power limit, and command 0x04 returns `pwr_max_mw`.
- R10: Any other command code returns 0x00000000 and still sets the completion flag.
- R11: A doorbell written while a request is still being serviced is ignored. The block is busy from the accepted doorbell until the result is posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pwr_meas_mw | input | 32 | Present power consumption in mW |
| pwr_max_mw | input | 32 | Highest allowed power limit in mW |
| alert | output | 1 | Completion alert, gated by the mask bit in control |

## Verification
The assertions assume three things about the inputs. Write strobes change only between clock edges. `pwr_max_mw` holds steady while a limit write is serviced, so the saturation bound is the one in force when the result is formed. The host does not clear the completion flag in the same cycle a result is posted. The bench keeps within these limits. It drives every input at the falling edge, changes the power inputs only between transactions, and issues a status write only after it has seen the flag set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam logic [7:0] ADDR_CTRL     = 8'h01;
    localparam logic [7:0] ADDR_STAT     = 8'h02;
    localparam logic [7:0] ADDR_OUT0     = 8'h30;
    localparam logic [7:0] ADDR_IN0      = 8'h38;
    localparam logic [7:0] ADDR_DOORBELL = 8'h40;
    localparam logic [7:0] DOORBELL_GO   = 8'h01;
    localparam int         MSG_BYTES     = 8;
    localparam int         STAT_DONE_BIT = 1;
    localparam int         CTRL_MASK_BIT = 4;

    localparam logic [7:0] CMD_PWR_RD = 8'h01;
    localparam logic [7:0] CMD_LIM_WR = 8'h02;
    localparam logic [7:0] CMD_LIM_RD = 8'h03;
    localparam logic [7:0] CMD_MAX_RD = 8'h04;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ISSUE,
        SEQ_WAIT,
        SEQ_POST
    } seq_state_e;
endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy_i,
    input  logic              post_i,
    input  logic [DATA_W-1:0] post_data_i,
    output logic              doorbell_o,
    output logic [7:0]        cmd_o,
    output logic [DATA_W-1:0] arg_o,
    output logic              done_o,
    output logic              mask_o
);
    localparam int ARG_BYTES = DATA_W / 8;

    logic [7:0]        ctrl_q;
    logic              done_q;
    logic [7:0]        in_q [MSG_BYTES];
    logic [DATA_W-1:0] resp_q;
    logic              stat_w1;
    logic [2:0]        out_idx;
    logic [DATA_W-1:0] resp_sh;

    assign stat_w1 = reg_we && (reg_addr == ADDR_STAT) && reg_wdata[STAT_DONE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            done_q <= 1'b0;
            resp_q <= '0;
            for (int i = 0; i < MSG_BYTES; i++) in_q[i] <= '0;
        end else begin
            if (reg_we && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata;
            for (int i = 0; i < MSG_BYTES; i++) begin
                if (reg_we && reg_addr == ADDR_IN0 + 8'(i)) in_q[i] <= reg_wdata;
            end
            if (post_i) begin
                resp_q <= post_data_i;
                done_q <= 1'b1;
            end else if (stat_w1) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < ARG_BYTES; k++) arg_o[k*8 +: 8] = in_q[k+1];
    end

    assign cmd_o      = in_q[0];
    assign done_o     = done_q;
    assign mask_o     = ctrl_q[CTRL_MASK_BIT];
    assign doorbell_o = reg_we && (reg_addr == ADDR_DOORBELL) &&
                        (reg_wdata == DOORBELL_GO) && !busy_i;

    assign out_idx = reg_addr[2:0] - 3'd1;
    assign resp_sh = resp_q >> {out_idx, 3'b000};

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata = ctrl_q;
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata[STAT_DONE_BIT] = done_q;
        end else if (reg_addr[7:3] == ADDR_IN0[7:3]) begin
            reg_rdata = in_q[reg_addr[2:0]];
        end else if (reg_addr >= ADDR_OUT0 + 8'd1 &&
                     reg_addr <= ADDR_OUT0 + 8'(ARG_BYTES)) begin
            reg_rdata = resp_sh[7:0];
        end
    end

    assert_post_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        post_i |=> done_q);
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1 && !post_i) |=> !done_q);
    assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !stat_w1) |=> done_q);
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              doorbell_i,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              busy_o,
    output logic              req_valid_o,
    output logic              post_o,
    output logic [DATA_W-1:0] post_data_o
);
    seq_state_e        state_q, state_d;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (doorbell_i)  state_d = SEQ_ISSUE;
            SEQ_ISSUE:                  state_d = SEQ_WAIT;
            SEQ_WAIT:  if (rsp_valid_i) state_d = SEQ_POST;
            SEQ_POST:                   state_d = SEQ_IDLE;
            default:                    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else if (state_q == SEQ_WAIT && rsp_valid_i) hold_q <= rsp_data_i;
    end

    always_comb begin
        busy_o      = (state_q != SEQ_IDLE);
        req_valid_o = (state_q == SEQ_ISSUE);
        post_o      = (state_q == SEQ_POST);
        post_data_o = hold_q;
    end

    assert_no_reissue_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_IDLE) |=> (state_q != SEQ_ISSUE));
    assert_post_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_POST) |=> (state_q == SEQ_IDLE));
    assert_rsp_when_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |-> (state_q == SEQ_WAIT));
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          RSP_LAT    = 3,
    parameter logic [31:0] LIMIT_INIT = 32'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [7:0]        req_cmd_i,
    input  logic [DATA_W-1:0] req_arg_i,
    input  logic [DATA_W-1:0] pwr_meas_i,
    input  logic [DATA_W-1:0] pwr_max_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    localparam int CNT_W = $clog2(RSP_LAT + 1);

    logic [7:0]        cmd_q;
    logic [DATA_W-1:0] arg_q;
    logic [DATA_W-1:0] limit_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] clamped;

    initial begin
        if (RSP_LAT < 1) $error("RSP_LAT must be at least 1");
    end

    assign clamped     = (arg_q > pwr_max_i) ? pwr_max_i : arg_q;
    assign rsp_valid_o = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            arg_q   <= '0;
            cnt_q   <= '0;
            limit_q <= DATA_W'(LIMIT_INIT);
        end else begin
            if (req_valid_i) begin
                cmd_q <= req_cmd_i;
                arg_q <= req_arg_i;
                cnt_q <= CNT_W'(RSP_LAT);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (rsp_valid_o && cmd_q == CMD_LIM_WR) limit_q <= clamped;
        end
    end

    always_comb begin
        unique case (cmd_q)
            CMD_PWR_RD: rsp_data_o = pwr_meas_i;
            CMD_LIM_WR: rsp_data_o = clamped;
            CMD_LIM_RD: rsp_data_o = limit_q;
            CMD_MAX_RD: rsp_data_o = pwr_max_i;
            default:    rsp_data_o = '0;
        endcase
    end

    assert_limit_saturated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && cmd_q == CMD_LIM_WR) |-> (rsp_data_o <= pwr_max_i));
    assert_limit_stored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && cmd_q == CMD_LIM_WR) |=> (limit_q == $past(rsp_data_o)));
    assert_unknown_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && (cmd_q == 8'h00 || cmd_q > CMD_MAX_RD)) |-> (rsp_data_o == '0));
endmodule

// File: rtl/mbx_target.sv
module mbx_target
    import mbx_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          RSP_LAT    = 3,
    parameter logic [31:0] LIMIT_INIT = 32'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [DATA_W-1:0] pwr_meas_mw,
    input  logic [DATA_W-1:0] pwr_max_mw,
    output logic              alert
);
    logic              busy, doorbell, post, done, mask;
    logic              req_valid, rsp_valid;
    logic [7:0]        cmd;
    logic [DATA_W-1:0] arg, rsp_data, post_data;

    mbx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy),
        .post_i(post), .post_data_i(post_data), .doorbell_o(doorbell),
        .cmd_o(cmd), .arg_o(arg), .done_o(done), .mask_o(mask)
    );

    mbx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .doorbell_i(doorbell), .rsp_valid_i(rsp_valid),
        .rsp_data_i(rsp_data), .busy_o(busy), .req_valid_o(req_valid),
        .post_o(post), .post_data_o(post_data)
    );

    mbx_responder #(.DATA_W(DATA_W), .RSP_LAT(RSP_LAT), .LIMIT_INIT(LIMIT_INIT)) u_rsp (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_cmd_i(cmd),
        .req_arg_i(arg), .pwr_meas_i(pwr_meas_mw), .pwr_max_i(pwr_max_mw),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
    );

    assign alert = done && !mask;

    assert_alert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !alert);
    assert_busy_until_post_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !post) |=> busy);
endmodule

// File: tb/mbx_target_test.sv
module mbx_target_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [31:0] pwr_meas_mw = 32'd0;
    logic [31:0] pwr_max_mw = 32'd0;
    logic        alert;

    int checks = 0;
    int fails = 0;
    logic [31:0] limit_m = 32'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_target uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_meas_mw(pwr_meas_mw),
        .pwr_max_mw(pwr_max_mw), .alert(alert)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rsp(input logic [7:0] c, input logic [31:0] a,
                                            input logic [31:0] meas, input logic [31:0] mx,
                                            input logic [31:0] lim);
        case (c)
            8'h01:   return meas;
            8'h02:   return (a > mx) ? mx : a;
            8'h03:   return lim;
            8'h04:   return mx;
            default: return 32'd0;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int n = 0; n < 40; n++) begin
            rd(8'h02, s);
            if (s[1]) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic load_req(input logic [7:0] c, input logic [31:0] a);
        wr(8'h3F, 8'h80);
        wr(8'h38, c);
        for (int b = 0; b < 4; b++) wr(8'h39 + 8'(b), a[b*8 +: 8]);
    endtask

    task automatic get_rsp(output logic [31:0] r);
        logic [7:0] d;
        for (int b = 0; b < 4; b++) begin
            rd(8'h31 + 8'(b), d);
            r[b*8 +: 8] = d;
        end
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [7:0] c, input logic [31:0] a, input string req);
        bit ok;
        logic [31:0] r, e;
        logic [7:0] s;
        e = exp_rsp(c, a, pwr_meas_mw, pwr_max_mw, limit_m);
        load_req(c, a);
        wr(8'h40, 8'h01);
        wait_done(ok);
        chk({req, " R4 flag set"}, 32'(ok), 32'd1);
        get_rsp(r);
        chk(req, r, e);
        if (c == 8'h02) limit_m = e;
        wr(8'h02, 8'h02);
        rd(8'h02, s);
        chk("R5 flag cleared", 32'(s[1]), 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [31:0] r;
        bit ok;
        void'($urandom(32'd20240611));
        pwr_meas_mw = 32'd45000;
        pwr_max_mw  = 32'd120000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h01, d); chk("R1 ctrl", 32'(d), 32'd0);
        rd(8'h02, d); chk("R1 status", 32'(d), 32'd0);
        rd(8'h3A, d); chk("R1 inbound", 32'(d), 32'd0);
        rd(8'h33, d); chk("R1 outbound", 32'(d), 32'd0);
        chk("R1 alert", 32'(alert), 32'd0);
        run_cmd(8'h03, 32'd0, "R1 limit after reset");

        // R2: map behaviour
        wr(8'h01, 8'hA5); rd(8'h01, d); chk("R2 ctrl readback", 32'(d), 32'hA5);
        wr(8'h01, 8'h00);
        wr(8'h3D, 8'h5C); rd(8'h3D, d); chk("R2 inbound readback", 32'(d), 32'h5C);
        wr(8'h10, 8'hFF); rd(8'h10, d); chk("R2 unmapped read", 32'(d), 32'd0);
        rd(8'h01, d); chk("R2 unmapped write no effect", 32'(d), 32'd0);
        rd(8'h41, d); chk("R2 read 0x41", 32'(d), 32'd0);
        rd(8'h40, d); chk("R2 doorbell reads zero", 32'(d), 32'd0);

        // R7/R4: power read, then outbound write ignored
        run_cmd(8'h01, 32'd0, "R7 power read");
        wr(8'h31, 8'hEE); rd(8'h31, d); chk("R2 outbound write ignored", 32'(d), 32'hC8);

        // R3: wrong doorbell value
        load_req(8'h04, 32'd0);
        wr(8'h40, 8'h02);
        repeat (10) @(negedge clk);
        rd(8'h02, d); chk("R3 no start on 0x02", 32'(d), 32'd0);

        // R8 saturation and R9
        run_cmd(8'h02, 32'd500000, "R8 limit saturated");
        run_cmd(8'h03, 32'd0, "R9 limit read");
        run_cmd(8'h04, 32'd0, "R9 max read");
        run_cmd(8'h02, 32'd77777, "R8 limit in range");
        run_cmd(8'h03, 32'd0, "R9 limit read 2");
        run_cmd(8'h9C, 32'hDEADBEEF, "R10 unknown command");

        // R5 write zero keeps flag, R6 alert gating
        load_req(8'h01, 32'd0);
        wr(8'h40, 8'h01);
        wait_done(ok);
        chk("R6 alert high", 32'(alert), 32'd1);
        wr(8'h02, 8'hFD);
        rd(8'h02, d); chk("R5 write zero keeps flag", 32'(d[1]), 32'd1);
        wr(8'h01, 8'h10); #1;
        chk("R6 alert masked", 32'(alert), 32'd0);
        wr(8'h01, 8'h00); #1;
        chk("R6 alert unmasked", 32'(alert), 32'd1);
        wr(8'h02, 8'h02); #1;
        chk("R6 alert after clear", 32'(alert), 32'd0);
        @(negedge clk);

        // R11: doorbell while busy
        load_req(8'h02, 32'd1000);
        wr(8'h40, 8'h01);
        @(negedge clk);
        wr(8'h39, 8'h22);
        wr(8'h40, 8'h01);
        wait_done(ok);
        get_rsp(r);
        chk("R11 first request served", r, 32'd1000);
        limit_m = 32'd1000;
        wr(8'h02, 8'h02);
        repeat (15) @(negedge clk);
        rd(8'h02, d); chk("R11 second doorbell ignored", 32'(d[1]), 32'd0);
        run_cmd(8'h03, 32'd0, "R11 limit unchanged");

        // Random mix
        for (int it = 0; it < 40; it++) begin
            logic [7:0] c;
            logic [31:0] a;
            int sel;
            sel = int'($urandom % 6);
            case (sel)
                0: c = 8'h01;
                1, 5: c = 8'h02;
                2: c = 8'h03;
                3: c = 8'h04;
                default: c = 8'h05 + 8'($urandom % 200);
            endcase
            a = ($urandom % 2) ? $urandom : ($urandom % 70000);
            pwr_meas_mw = $urandom % 300000;
            pwr_max_mw  = 32'd1000 + ($urandom % 64536);
            @(negedge clk);
            run_cmd(c, a, "R7 R8 R9 R10 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule